// File: doc/BRIEF.md
# Profiling Register Access Trap Resolver

This block decides what happens when software tries to read or write a protected profiling-control register. It is purely combinational. It takes the requesting exception level, the halted-debug and secure-debug-disable state, which higher levels exist, the current security state, a 2-bit owner field, and a set of hypervisor and monitor trap controls. It reduces all of these to one 3-bit outcome code. The instruction-execution pipeline uses this code to commit the access, raise an undefined-instruction exception, route a trap to a higher level, or redirect the access to a memory slot.

The conditions are tested in a fixed order, and the first one that matches wins. Alongside the outcome the block reports the trap target level, the syndrome exception class for traps, and the memory offset for redirected accesses. A parameter selects the implementation option that lets the halted secure-debug check take priority over every hypervisor trap.

Top module: `accessTrapResolver`

## Requirements
- R1: When `curLevel` is 0, the outcome is 1 (undefined), whatever the other inputs are.
- R2: When `curLevel` is 3, the outcome is 0 (direct access), whatever the other inputs are.
- R3: With `HALT_UNDEF_FIRST` = 1 and `curLevel` of 1 or 2, the outcome is 1 when all of these hold: halted, secure debug disabled, EL3 present, and owner mismatch. This check wins over every hypervisor trap. The owner field matches when it is 2'b11 in the non-secure state, or 2'b01 in the secure state.
- R4: At level 1, the outcome is 2 (trap to EL2) when all of these hold: EL2 is enabled, fine-grained trapping is permitted, and the trap bit for the access direction is set. Fine-grained trapping is permitted when EL3 is absent or `fineTrapEnable` is 1. `isWrite` = 1 selects `fineWriteTrap`; otherwise `fineReadTrap` is used.
- R5: At level 1, if R4 does not apply, the outcome is 2 when EL2 is enabled and `coarseTrap` is 1.
- R6: At level 1 or 2, if no earlier rule applies, an owner mismatch with EL3 present gives outcome 3 (trap to EL3). If the core is also halted with secure debug disabled, the outcome is 1 instead.
- R7: At level 1, if no earlier rule applies, the outcome is 4 (memory redirect) when EL2 is enabled and `nestCtl` matches 3'b1x1.
- R8: At level 2, the fine-grained trap, coarse trap and nested-control inputs have no effect.
- R9: Trap outcomes drive `trapLevel` to 2 or 3 and `syndromeClass` to 6'h18; other outcomes drive both to 0. `memOffset` is 12'h830 only for a redirect and 0 otherwise.
- R10: EL2 counts as enabled only when `hasEl2` is 1 and either `nonSecure` or `secEl2Enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curLevel | input | 2 | Requesting exception level, 0 to 3 |
| haltedDbg | input | 1 | Core is in halted debug state |
| secDbgOff | input | 1 | Secure debug disabled |
| hasEl2 | input | 1 | EL2 is implemented |
| hasEl3 | input | 1 | EL3 is implemented |
| nonSecure | input | 1 | Current security state is non-secure |
| ownerField | input | 2 | Owning-state field from the monitor |
| fineTrapEnable | input | 1 | Monitor permits fine-grained traps |
| fineReadTrap | input | 1 | Fine-grained trap bit for reads |
| fineWriteTrap | input | 1 | Fine-grained trap bit for writes |
| isWrite | input | 1 | Access is a write |
| secEl2Enable | input | 1 | EL2 is enabled in the secure state |
| coarseTrap | input | 1 | Hypervisor coarse profiling trap |
| nestCtl | input | 3 | Nested virtualisation controls {NV2, NV1, NV} |
| accessOutcome | output | 3 | 0 direct, 1 undefined, 2 trap EL2, 3 trap EL3, 4 redirect |
| trapLevel | output | 2 | Target level for traps, else 0 |
| syndromeClass | output | 6 | Exception class for traps, else 0 |
| memOffset | output | 12 | Redirect offset, else 0 |

## Verification
The bench targets the places where two rules overlap and their order decides the result:
- A halted core with an owner mismatch and a pending fine-grained trap. A design with a misplaced debug check would return trap to EL2 here instead of undefined.
- A fine-grained trap bit set while the monitor withholds permission. A design that ignored the permission gate would trap.
- A secure access with `secEl2Enable` clear. A design that treated an implemented EL2 as enabled would trap or redirect.
- The don't-care middle bit of the nested pattern. A decoder that compared all three bits would miss the 3'b101 redirect.
- Level 2 accesses with every hypervisor control set. These must still go direct.

A long random sweep against an independent priority model covers the remaining combinations. It also checks the level, syndrome and offset outputs that go with each outcome.

// File: rtl/accessTrapPkg.sv
package accessTrapPkg;

  localparam int LEVEL_W   = 2;
  localparam int OUTCOME_W = 3;
  localparam int OWNER_W   = 2;
  localparam int NEST_W    = 3;
  localparam int NUM_LEVELS = 1 << LEVEL_W;

  localparam logic [OWNER_W-1:0] OWNER_SECURE    = 2'b01;
  localparam logic [OWNER_W-1:0] OWNER_NONSECURE = 2'b11;

  localparam logic [5:0]  SYND_CLASS_DEF      = 6'h18;
  localparam logic [11:0] REDIRECT_OFFSET_DEF = 12'h830;

  typedef enum logic [OUTCOME_W-1:0] {
    OUT_DIRECT   = 3'd0,
    OUT_UNDEF    = 3'd1,
    OUT_TRAP_EL2 = 3'd2,
    OUT_TRAP_EL3 = 3'd3,
    OUT_REDIRECT = 3'd4
  } accessOutcome_t;

  // Condition strobes raised by the control side, consumed by the selector.
  typedef struct packed {
    logic atEl0;
    logic atEl1;
    logic atEl2;
    logic atEl3;
    logic haltUndef;
    logic fineHit;
    logic coarseHit;
    logic ownerMiss;
    logic ownerUndef;
    logic nestRedirect;
  } trapStrobes_t;

endpackage

// File: rtl/trapCondCtrl.sv
module trapCondCtrl
  import accessTrapPkg::*;
#(
  parameter bit HALT_UNDEF_FIRST = 1'b1
) (
  input  logic [LEVEL_W-1:0] curLevel,
  input  logic               haltedDbg,
  input  logic               secDbgOff,
  input  logic               hasEl2,
  input  logic               hasEl3,
  input  logic               nonSecure,
  input  logic [OWNER_W-1:0] ownerField,
  input  logic               fineTrapEnable,
  input  logic               fineReadTrap,
  input  logic               fineWriteTrap,
  input  logic               isWrite,
  input  logic               secEl2Enable,
  input  logic               coarseTrap,
  input  logic [NEST_W-1:0]  nestCtl,
  output trapStrobes_t       strobes
);

  logic [NUM_LEVELS-1:0] levelHot;
  logic el2Enabled;
  logic ownerOk;
  logic dbgLocked;
  logic fineAllowed;
  logic fineBit;
  logic haltUndefRaw;

  // One-hot decode of the requesting level.
  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_levelDecode
    assign levelHot[lv] = (curLevel == LEVEL_W'(lv));
  end

  assign el2Enabled  = hasEl2 & (nonSecure | secEl2Enable);
  assign ownerOk     = nonSecure ? (ownerField == OWNER_NONSECURE)
                                 : (ownerField == OWNER_SECURE);
  assign dbgLocked   = haltedDbg & secDbgOff;
  assign fineAllowed = ~hasEl3 | fineTrapEnable;
  assign fineBit     = isWrite ? fineWriteTrap : fineReadTrap;

  // Implementation option: halted secure-debug check ahead of hypervisor traps.
  if (HALT_UNDEF_FIRST) begin : g_haltFirst
    assign haltUndefRaw = dbgLocked & hasEl3 & ~ownerOk;
  end else begin : g_haltLate
    assign haltUndefRaw = 1'b0;
  end

  always_comb begin
    strobes.atEl0        = levelHot[0];
    strobes.atEl1        = levelHot[1];
    strobes.atEl2        = levelHot[2];
    strobes.atEl3        = levelHot[3];
    strobes.haltUndef    = haltUndefRaw;
    strobes.fineHit      = el2Enabled & fineAllowed & fineBit;
    strobes.coarseHit    = el2Enabled & coarseTrap;
    strobes.ownerMiss    = hasEl3 & ~ownerOk;
    strobes.ownerUndef   = hasEl3 & ~ownerOk & dbgLocked;
    strobes.nestRedirect = el2Enabled & nestCtl[2] & nestCtl[0];
  end

endmodule

// File: rtl/trapOutcomeSel.sv
module trapOutcomeSel
  import accessTrapPkg::*;
#(
  parameter int          SYND_W          = 6,
  parameter logic [SYND_W-1:0] SYND_CLASS = SYND_CLASS_DEF,
  parameter int          OFF_W           = 12,
  parameter logic [OFF_W-1:0] REDIRECT_OFFSET = REDIRECT_OFFSET_DEF
) (
  input  trapStrobes_t        strobes,
  output logic [OUTCOME_W-1:0] accessOutcome,
  output logic [LEVEL_W-1:0]   trapLevel,
  output logic [SYND_W-1:0]    syndromeClass,
  output logic [OFF_W-1:0]     memOffset
);

  accessOutcome_t outSel;

  // Ordered priority chain; first matching rule wins.
  always_comb begin
    outSel = OUT_DIRECT;
    if (strobes.atEl0) begin
      outSel = OUT_UNDEF;
    end else if (strobes.atEl3) begin
      outSel = OUT_DIRECT;
    end else if (strobes.atEl1 || strobes.atEl2) begin
      if (strobes.haltUndef) begin
        outSel = OUT_UNDEF;
      end else if (strobes.atEl1 && strobes.fineHit) begin
        outSel = OUT_TRAP_EL2;
      end else if (strobes.atEl1 && strobes.coarseHit) begin
        outSel = OUT_TRAP_EL2;
      end else if (strobes.ownerMiss) begin
        outSel = strobes.ownerUndef ? OUT_UNDEF : OUT_TRAP_EL3;
      end else if (strobes.atEl1 && strobes.nestRedirect) begin
        outSel = OUT_REDIRECT;
      end else begin
        outSel = OUT_DIRECT;
      end
    end
  end

  always_comb begin
    accessOutcome = outSel;
    trapLevel     = '0;
    syndromeClass = '0;
    memOffset     = '0;
    unique case (outSel)
      OUT_TRAP_EL2: begin
        trapLevel     = LEVEL_W'(2);
        syndromeClass = SYND_CLASS;
      end
      OUT_TRAP_EL3: begin
        trapLevel     = LEVEL_W'(3);
        syndromeClass = SYND_CLASS;
      end
      OUT_REDIRECT: memOffset = REDIRECT_OFFSET;
      default: ;
    endcase
  end

endmodule

// File: rtl/accessTrapResolver.sv
module accessTrapResolver
  import accessTrapPkg::*;
#(
  parameter bit   HALT_UNDEF_FIRST = 1'b1,
  parameter int   SYND_W           = 6,
  parameter logic [SYND_W-1:0] SYND_CLASS = SYND_CLASS_DEF,
  parameter int   OFF_W            = 12,
  parameter logic [OFF_W-1:0] REDIRECT_OFFSET = REDIRECT_OFFSET_DEF
) (
  input  logic [1:0]        curLevel,
  input  logic              haltedDbg,
  input  logic              secDbgOff,
  input  logic              hasEl2,
  input  logic              hasEl3,
  input  logic              nonSecure,
  input  logic [1:0]        ownerField,
  input  logic              fineTrapEnable,
  input  logic              fineReadTrap,
  input  logic              fineWriteTrap,
  input  logic              isWrite,
  input  logic              secEl2Enable,
  input  logic              coarseTrap,
  input  logic [2:0]        nestCtl,
  output logic [2:0]        accessOutcome,
  output logic [1:0]        trapLevel,
  output logic [SYND_W-1:0] syndromeClass,
  output logic [OFF_W-1:0]  memOffset
);

  trapStrobes_t strobes;

  trapCondCtrl #(
    .HALT_UNDEF_FIRST(HALT_UNDEF_FIRST)
  ) i_trapCondCtrl (
    .curLevel      (curLevel),
    .haltedDbg     (haltedDbg),
    .secDbgOff     (secDbgOff),
    .hasEl2        (hasEl2),
    .hasEl3        (hasEl3),
    .nonSecure     (nonSecure),
    .ownerField    (ownerField),
    .fineTrapEnable(fineTrapEnable),
    .fineReadTrap  (fineReadTrap),
    .fineWriteTrap (fineWriteTrap),
    .isWrite       (isWrite),
    .secEl2Enable  (secEl2Enable),
    .coarseTrap    (coarseTrap),
    .nestCtl       (nestCtl),
    .strobes       (strobes)
  );

  trapOutcomeSel #(
    .SYND_W         (SYND_W),
    .SYND_CLASS     (SYND_CLASS),
    .OFF_W          (OFF_W),
    .REDIRECT_OFFSET(REDIRECT_OFFSET)
  ) i_trapOutcomeSel (
    .strobes      (strobes),
    .accessOutcome(accessOutcome),
    .trapLevel    (trapLevel),
    .syndromeClass(syndromeClass),
    .memOffset    (memOffset)
  );

endmodule

// File: rtl/accessTrapChecker.sv
module accessTrapChecker (
  input logic [1:0]  curLevel,
  input logic        haltedDbg,
  input logic        secDbgOff,
  input logic        hasEl3,
  input logic        nonSecure,
  input logic [1:0]  ownerField,
  input logic [2:0]  accessOutcome,
  input logic [1:0]  trapLevel,
  input logic [5:0]  syndromeClass,
  input logic [11:0] memOffset
);

  logic ownerBad;
  assign ownerBad = hasEl3 & (nonSecure ? (ownerField != 2'b11) : (ownerField != 2'b01));

  always_comb begin
    if (!$isunknown({curLevel, haltedDbg, secDbgOff, hasEl3, nonSecure, ownerField,
                     accessOutcome, trapLevel, syndromeClass, memOffset})) begin
      AST_EL0_UNDEF: assert (curLevel != 2'd0 || accessOutcome == 3'd1)
        else $error("level 0 access not undefined"); // R1
      AST_EL3_DIRECT: assert (curLevel != 2'd3 || accessOutcome == 3'd0)
        else $error("level 3 access not direct"); // R2
      AST_EL2_NO_HYP: assert (curLevel != 2'd2 || (accessOutcome != 3'd2 && accessOutcome != 3'd4))
        else $error("level 2 access hit hypervisor rule"); // R8
      AST_EL2_LOCKED_UNDEF: assert (!(curLevel == 2'd2 && ownerBad && haltedDbg && secDbgOff) || accessOutcome == 3'd1)
        else $error("locked owner mismatch not undefined"); // R6
      AST_TRAP_SYNDROME: assert ((accessOutcome == 3'd2 || accessOutcome == 3'd3) == (syndromeClass == 6'h18))
        else $error("syndrome class mismatched to trap"); // R9
      AST_TRAP_TARGET: assert ((accessOutcome == 3'd2) == (trapLevel == 2'd2) && (accessOutcome == 3'd3) == (trapLevel == 2'd3))
        else $error("trap target level mismatched"); // R9
      AST_REDIRECT_ONLY_EL1: assert (accessOutcome != 3'd4 || (curLevel == 2'd1 && memOffset == 12'h830))
        else $error("redirect outside level 1 or bad offset"); // R7
    end
  end

endmodule

bind accessTrapResolver accessTrapChecker i_accessTrapChecker (
  .curLevel     (curLevel),
  .haltedDbg    (haltedDbg),
  .secDbgOff    (secDbgOff),
  .hasEl3       (hasEl3),
  .nonSecure    (nonSecure),
  .ownerField   (ownerField),
  .accessOutcome(accessOutcome),
  .trapLevel    (trapLevel),
  .syndromeClass(syndromeClass),
  .memOffset    (memOffset)
);

// File: tb/test_accessTrapResolver.sv
module test_accessTrapResolver;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]  curLevel;
  logic        haltedDbg, secDbgOff, hasEl2, hasEl3, nonSecure;
  logic [1:0]  ownerField;
  logic        fineTrapEnable, fineReadTrap, fineWriteTrap, isWrite;
  logic        secEl2Enable, coarseTrap;
  logic [2:0]  nestCtl;
  logic [2:0]  accessOutcome;
  logic [1:0]  trapLevel;
  logic [5:0]  syndromeClass;
  logic [11:0] memOffset;

  accessTrapResolver i_accessTrapResolver (
    .curLevel(curLevel), .haltedDbg(haltedDbg), .secDbgOff(secDbgOff),
    .hasEl2(hasEl2), .hasEl3(hasEl3), .nonSecure(nonSecure),
    .ownerField(ownerField), .fineTrapEnable(fineTrapEnable),
    .fineReadTrap(fineReadTrap), .fineWriteTrap(fineWriteTrap),
    .isWrite(isWrite), .secEl2Enable(secEl2Enable), .coarseTrap(coarseTrap),
    .nestCtl(nestCtl), .accessOutcome(accessOutcome), .trapLevel(trapLevel),
    .syndromeClass(syndromeClass), .memOffset(memOffset)
  );

  typedef struct {
    logic [17:0] vec;
    logic [2:0]  oc;
    string       tag;
  } expItem_t;

  expItem_t sb[$];
  int checks = 0;
  int failures = 0;
  bit allDriven = 1'b0;

  // Vector layout: [1:0] level, [2] halted, [3] secDbgOff, [4] hasEl2, [5] hasEl3,
  // [6] nonSecure, [8:7] owner, [9] fineEn, [10] fineRd, [11] fineWr, [12] isWrite,
  // [13] secEl2En, [14] coarse, [17:15] nest
  function automatic logic [17:0] mk(input logic [1:0] lv, input logic h, input logic sd,
      input logic e2, input logic e3, input logic ns, input logic [1:0] ow,
      input logic fe, input logic fr, input logic fw, input logic wr,
      input logic se2, input logic co, input logic [2:0] nv);
    return {nv, co, se2, wr, fw, fr, fe, ow, ns, e3, e2, sd, h, lv};
  endfunction

  // Independent priority model written from the requirements.
  function automatic void refModel(input logic [17:0] v, output logic [2:0] oc, output string tag);
    logic el2en, ownOk, miss, lock, fbit;
    el2en = v[4] & (v[6] | v[13]);
    ownOk = v[6] ? (v[8:7] == 2'b11) : (v[8:7] == 2'b01);
    miss  = v[5] & ~ownOk;
    lock  = v[2] & v[3];
    fbit  = v[12] ? v[11] : v[10];
    if (v[1:0] == 2'd0) begin oc = 3'd1; tag = "R1"; end
    else if (v[1:0] == 2'd3) begin oc = 3'd0; tag = "R2"; end
    else if (lock && miss) begin oc = 3'd1; tag = "R3"; end
    else if (v[1:0] == 2'd1 && el2en && (!v[5] || v[9]) && fbit) begin oc = 3'd2; tag = "R4"; end
    else if (v[1:0] == 2'd1 && el2en && v[14]) begin oc = 3'd2; tag = "R5"; end
    else if (miss) begin oc = 3'd3; tag = "R6"; end
    else if (v[1:0] == 2'd1 && el2en && v[17] && v[15]) begin oc = 3'd4; tag = "R7"; end
    else begin oc = 3'd0; tag = (v[1:0] == 2'd2) ? "R8" : "R10"; end
  endfunction

  task automatic drive(input logic [17:0] v, input logic [2:0] oc, input string tag);
    expItem_t it;
    @(posedge clk);
    {nestCtl, coarseTrap, secEl2Enable, isWrite, fineWriteTrap, fineReadTrap,
     fineTrapEnable, ownerField, nonSecure, hasEl3, hasEl2, secDbgOff, haltedDbg, curLevel} = v;
    it.vec = v; it.oc = oc; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic driveRef(input logic [17:0] v);
    logic [2:0] oc;
    string tag;
    refModel(v, oc, tag);
    drive(v, oc, tag);
  endtask

  // Monitor: compares at the falling edge, away from the driving edge.
  initial begin
    expItem_t it;
    logic [1:0]  eLvl;
    logic [5:0]  eSyn;
    logic [11:0] eOff;
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        it = sb.pop_front();
        eLvl = (it.oc == 3'd2) ? 2'd2 : (it.oc == 3'd3) ? 2'd3 : 2'd0;
        eSyn = (it.oc == 3'd2 || it.oc == 3'd3) ? 6'h18 : 6'h00;
        eOff = (it.oc == 3'd4) ? 12'h830 : 12'h000;
        checks++;
        if (accessOutcome !== it.oc) begin
          failures++;
          $display("FAIL %s vec=%h outcome actual=%0d expected=%0d", it.tag, it.vec, accessOutcome, it.oc);
        end else if (trapLevel !== eLvl || syndromeClass !== eSyn || memOffset !== eOff) begin
          failures++;
          $display("FAIL R9 vec=%h level/syn/off actual=%0d/%h/%h expected=%0d/%h/%h",
                   it.vec, trapLevel, syndromeClass, memOffset, eLvl, eSyn, eOff);
        end
      end
    end
  end

  initial begin
    {nestCtl, coarseTrap, secEl2Enable, isWrite, fineWriteTrap, fineReadTrap,
     fineTrapEnable, ownerField, nonSecure, hasEl3, hasEl2, secDbgOff, haltedDbg, curLevel} = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Initial state, all-zero inputs: level 0 undefined (R1)
    drive('0, 3'd1, "R1");
    drive(mk(0,1,1,1,1,1,2'b00,1,1,1,1,1,1,3'b111), 3'd1, "R1");
    // R2: level 3 direct despite locked debug and owner mismatch
    drive(mk(3,1,1,1,1,1,2'b01,1,1,1,0,1,1,3'b101), 3'd0, "R2");
    // R3: halted lock beats pending fine-grained and coarse traps
    drive(mk(1,1,1,1,1,1,2'b01,1,1,1,0,0,1,3'b000), 3'd1, "R3");
    // R4: read trap bit selected
    drive(mk(1,0,0,1,1,1,2'b11,1,1,0,0,0,0,3'b000), 3'd2, "R4");
    // R4: write selects write bit, which is clear
    drive(mk(1,0,0,1,1,1,2'b11,1,1,0,1,0,0,3'b000), 3'd0, "R4");
    // R4: monitor withholds fine-grained permission
    drive(mk(1,0,0,1,1,1,2'b11,0,1,1,0,0,0,3'b000), 3'd0, "R4");
    // R4: EL3 absent permits fine-grained traps
    drive(mk(1,0,0,1,0,1,2'b00,0,0,1,1,0,0,3'b000), 3'd2, "R4");
    // R10: secure, secure EL2 disabled -> no trap; enabled -> trap
    drive(mk(1,0,0,1,0,0,2'b00,0,1,0,0,0,1,3'b101), 3'd0, "R10");
    drive(mk(1,0,0,1,0,0,2'b00,0,1,0,0,1,0,3'b000), 3'd2, "R10");
    drive(mk(1,0,0,0,0,1,2'b00,1,1,1,0,1,1,3'b101), 3'd0, "R10");
    // R5: coarse trap alone
    drive(mk(1,0,0,1,1,1,2'b11,1,0,0,0,0,1,3'b000), 3'd2, "R5");
    // R6: owner mismatch at level 2 traps to EL3, locked -> undefined
    drive(mk(2,0,0,1,1,0,2'b11,0,0,0,0,1,0,3'b000), 3'd3, "R6");
    drive(mk(2,1,1,1,1,0,2'b11,0,0,0,0,1,0,3'b000), 3'd1, "R6");
    drive(mk(1,1,0,1,1,0,2'b00,0,0,0,0,0,0,3'b000), 3'd3, "R6");
    // R7: nested pattern with don't-care middle bit
    drive(mk(1,0,0,1,1,1,2'b11,0,0,0,0,0,0,3'b101), 3'd4, "R7");
    drive(mk(1,0,0,1,1,1,2'b11,0,0,0,0,0,0,3'b111), 3'd4, "R7");
    drive(mk(1,0,0,1,1,1,2'b11,0,0,0,0,0,0,3'b100), 3'd0, "R7");
    drive(mk(1,0,0,1,1,1,2'b11,0,0,0,0,0,0,3'b001), 3'd0, "R7");
    // R8: level 2 ignores hypervisor controls
    drive(mk(2,0,0,1,1,1,2'b11,1,1,1,0,1,1,3'b111), 3'd0, "R8");
    drive(mk(2,0,0,1,0,0,2'b00,0,1,1,1,1,1,3'b101), 3'd0, "R8");
    // Random sweep against the reference model
    for (int i = 0; i < 20000; i++) begin
      driveRef(18'($urandom()));
    end
    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    allDriven = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!allDriven) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule